// File: doc/BRIEF.md
# Coprocessor Shared-RAM Host Window

This block gives a host processor byte-wide access to the local RAM of an I/O coprocessor. The host sees four registers, picked by a two-bit select: the low and high bytes of a RAM pointer, a data window, and a control/status byte. A read or write of the data window moves one byte between the host and the RAM location named by the pointer. When auto-advance is on, the pointer steps by one after each window access. A whole block can then be loaded, fetched or compared after setting the address only once.

The control/status byte has three control bits: run (the coprocessor executes), bypass, and auto-advance. It also has a doorbell bit. Writing the doorbell as 1 sends a one-cycle interrupt to the coprocessor. Two event flags let the coprocessor signal the host. One flag means outbound work is complete. The other means a new inbound message is waiting. Either flag drives one shared host interrupt line. The host clears a flag by writing 1 to its bit, and in the same write it restates run and auto-advance.

The coprocessor side is a small request port. One strobe sets each flag, and a write request reaches the single-port RAM when the host is not using the data window. Software conventions use the RAM as ordinary memory, for example a liveness byte that the coprocessor sets to 0xFF and the host clears to 0.

Top module: `shram_host_port`

## Requirements
- R1: After reset the pointer is 0x0000, the control/status byte reads 0x00, and `cop_run`, `cop_bypass`, `cop_irq` and `host_irq` are 0.
- R2: A write with select 0 loads pointer bits 7:0. A write with select 1 loads pointer bits 15:8. Reads of the same selects return those bytes, with `host_rvalid` high in the cycle after the read request.
- R3: Select 2 is the data window. A write stores `host_wdata` at the RAM location given by the pointer. A read returns the byte at that location on `host_rdata`, with `host_rvalid` high in the following cycle.
- R4: With auto-advance (bit 1) set, each data-window access adds one to the pointer. With it clear, the pointer does not change.
- R5: Advancing from pointer 0xFFFF gives 0x0000.
- R6: Select 3 is the control/status byte: bit0 run, bit1 auto-advance, bit2 bypass, bit3 doorbell, bit4 completion flag, bit5 new-message flag, bits 7:6 read 0. A write sets run, auto-advance and bypass to the written values, and `cop_run` and `cop_bypass` follow them.
- R7: Writing bit3 as 1 drives `cop_irq` high for exactly the cycle after the write. After that it reads 0 and `cop_irq` is low.
- R8: `cop_set_int0` and `cop_set_int1` set bit4 and bit5. `host_irq` rises two clock edges after the set strobe and stays high while either flag is set.
- R9: A control write clears only the flag bits it writes as 1. A flag written as 0 keeps its value.
- R10: If a set strobe and a host clear of the same flag fall in the same cycle, the flag ends up set.
- R11: A coprocessor write request is granted (`cop_gnt`) and performed only in cycles with no host data-window access. Host window accesses always win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Register select: 0 ptr low, 1 ptr high, 2 data, 3 control/status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (ignored when host_wr is high) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| host_irq | output | 1 | Shared host interrupt, OR of the two flags, registered |
| ram_addr | output | ADDR_W | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after the address |
| cop_run | output | 1 | Run enable for the coprocessor |
| cop_bypass | output | 1 | Bypass mode toward the coprocessor |
| cop_irq | output | 1 | One-cycle doorbell interrupt to the coprocessor |
| cop_wr | input | 1 | Coprocessor RAM write request |
| cop_addr | input | ADDR_W | Coprocessor write address |
| cop_wdata | input | 8 | Coprocessor write byte |
| cop_gnt | output | 1 | Coprocessor write granted this cycle |
| cop_set_int0 | input | 1 | Set the completion flag |
| cop_set_int1 | input | 1 | Set the new-message flag |

## Verification
A corrupted pointer does not show up as a bad address at once. It shows up as the wrong byte on the next window read, or as a wrong value when the pointer bytes are read back one cycle after the request. So the bench reads the pointer back after each burst. Flag state errors show in the control/status readback and, one edge later, on `host_irq`. That is why flag checks sample both the readback and the interrupt line at exact cycle offsets. A doorbell that sticks or is lost shows on `cop_irq` in the cycle right after the write, so that cycle and the one after it are both checked.

// File: rtl/shram_pkg.sv
package shram_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        REG_PTR_LO = 2'd0,
        REG_PTR_HI = 2'd1,
        REG_DATA   = 2'd2,
        REG_CTRL   = 2'd3
    } reg_sel_e;

    // control/status bit positions
    localparam int CB_RUN     = 0;
    localparam int CB_AUTOINC = 1;
    localparam int CB_BYPASS  = 2;
    localparam int CB_DOORBELL = 3;
    localparam int CB_INT0    = 4;
    localparam int CB_INT1    = 5;

    typedef struct packed {
        logic run;
        logic autoinc;
        logic bypass;
        logic doorbell;
        logic int0;
        logic int1;
        logic hirq;
    } ctrl_state_t;

    typedef struct packed {
        logic              rvalid;
        logic              from_ram;
        logic [BYTE_W-1:0] rbyte;
    } rd_state_t;

endpackage

// File: rtl/shram_ptr.sv
module shram_ptr
    import shram_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              step,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_lo) begin
            ptr_d[BYTE_W-1:0] = byte_in;
        end else if (load_hi) begin
            ptr_d[ADDR_W-1:BYTE_W] = byte_in[HI_W-1:0];
        end else if (step) begin
            // natural modulo wrap at the top of the address space
            ptr_d = ptr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
    import shram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              set_int0,
    input  logic              set_int1,
    output logic              run,
    output logic              autoinc,
    output logic              bypass,
    output logic              doorbell,
    output logic              hirq,
    output logic [BYTE_W-1:0] status
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.run     = wbyte[CB_RUN];
            st_d.autoinc = wbyte[CB_AUTOINC];
            st_d.bypass  = wbyte[CB_BYPASS];
        end
        // doorbell lives one cycle only
        st_d.doorbell = wr_ctrl & wbyte[CB_DOORBELL];
        // write-one-to-clear, a set strobe in the same cycle wins
        st_d.int0 = (st_q.int0 & ~(wr_ctrl & wbyte[CB_INT0])) | set_int0;
        st_d.int1 = (st_q.int1 & ~(wr_ctrl & wbyte[CB_INT1])) | set_int1;
        st_d.hirq = st_q.int0 | st_q.int1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status              = '0;
        status[CB_RUN]      = st_q.run;
        status[CB_AUTOINC]  = st_q.autoinc;
        status[CB_BYPASS]   = st_q.bypass;
        status[CB_DOORBELL] = st_q.doorbell;
        status[CB_INT0]     = st_q.int0;
        status[CB_INT1]     = st_q.int1;
    end

    assign run      = st_q.run;
    assign autoinc  = st_q.autoinc;
    assign bypass   = st_q.bypass;
    assign doorbell = st_q.doorbell;
    assign hirq     = st_q.hirq;

endmodule

// File: rtl/shram_port_mux.sv
module shram_port_mux
    import shram_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sel,
    input  logic              rd_eff,
    input  logic              wr_data,
    input  logic              data_acc,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [BYTE_W-1:0] status,
    input  logic              cop_wr,
    input  logic [ADDR_W-1:0] cop_addr,
    input  logic [BYTE_W-1:0] cop_wdata,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [BYTE_W-1:0] ram_wdata,
    output logic              cop_gnt,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_rvalid
);
    localparam int HI_W = ADDR_W - BYTE_W;

    rd_state_t         rd_d, rd_q;
    logic [BYTE_W-1:0] hi_byte;

    // RAM side: host window has priority over coprocessor writes
    always_comb begin
        cop_gnt   = cop_wr & ~data_acc;
        ram_addr  = ptr;
        ram_we    = 1'b0;
        ram_wdata = host_wdata;
        if (data_acc) begin
            ram_we = wr_data;
        end else if (cop_wr) begin
            ram_addr  = cop_addr;
            ram_we    = 1'b1;
            ram_wdata = cop_wdata;
        end
    end

    always_comb begin
        hi_byte             = '0;
        hi_byte[HI_W-1:0]   = ptr[ADDR_W-1:BYTE_W];
    end

    always_comb begin
        rd_d          = rd_q;
        rd_d.rvalid   = rd_eff;
        rd_d.from_ram = 1'b0;
        if (rd_eff) begin
            case (reg_sel_e'(sel))
                REG_PTR_LO: rd_d.rbyte = ptr[BYTE_W-1:0];
                REG_PTR_HI: rd_d.rbyte = hi_byte;
                REG_DATA: begin
                    rd_d.rbyte    = '0;
                    rd_d.from_ram = 1'b1;
                end
                default:    rd_d.rbyte = status;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign host_rdata  = rd_q.from_ram ? ram_rdata : rd_q.rbyte;
    assign host_rvalid = rd_q.rvalid;

endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
    import shram_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_rvalid,
    output logic              host_irq,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              cop_run,
    output logic              cop_bypass,
    output logic              cop_irq,
    input  logic              cop_wr,
    input  logic [ADDR_W-1:0] cop_addr,
    input  logic [7:0]        cop_wdata,
    output logic              cop_gnt,
    input  logic              cop_set_int0,
    input  logic              cop_set_int1
);
    logic              rd_eff;
    logic              data_acc;
    logic              autoinc;
    logic              step;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] status;

    assign rd_eff   = host_rd & ~host_wr;
    assign data_acc = (host_wr | rd_eff) & (reg_sel_e'(host_sel) == REG_DATA);
    assign step     = data_acc & autoinc;

    shram_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (host_wr & (reg_sel_e'(host_sel) == REG_PTR_LO)),
        .load_hi (host_wr & (reg_sel_e'(host_sel) == REG_PTR_HI)),
        .step    (step),
        .byte_in (host_wdata),
        .ptr     (ptr)
    );

    shram_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (host_wr & (reg_sel_e'(host_sel) == REG_CTRL)),
        .wbyte    (host_wdata),
        .set_int0 (cop_set_int0),
        .set_int1 (cop_set_int1),
        .run      (cop_run),
        .autoinc  (autoinc),
        .bypass   (cop_bypass),
        .doorbell (cop_irq),
        .hirq     (host_irq),
        .status   (status)
    );

    shram_port_mux #(.ADDR_W(ADDR_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (host_sel),
        .rd_eff      (rd_eff),
        .wr_data     (host_wr),
        .data_acc    (data_acc),
        .host_wdata  (host_wdata),
        .ptr         (ptr),
        .status      (status),
        .cop_wr      (cop_wr),
        .cop_addr    (cop_addr),
        .cop_wdata   (cop_wdata),
        .ram_rdata   (ram_rdata),
        .ram_addr    (ram_addr),
        .ram_we      (ram_we),
        .ram_wdata   (ram_wdata),
        .cop_gnt     (cop_gnt),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

endmodule

// File: rtl/shram_host_port_chk.sv
module shram_host_port_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        host_sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_wdata,
    input logic              host_rvalid,
    input logic              host_irq,
    input logic              cop_irq,
    input logic              cop_gnt,
    input logic              cop_set_int0,
    input logic              cop_set_int1,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [ADDR_W-1:0] ptr,
    input logic              autoinc
);
    logic win;
    logic loads;
    assign win   = (host_wr | host_rd) & (host_sel == 2'd2);
    assign loads = host_wr & (host_sel == 2'd0 || host_sel == 2'd1);

    p_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rvalid);

    p_ram_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> (ram_addr == ptr));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win && autoinc) |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!win && !loads) |=> $stable(ptr));

    p_doorbell_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq |=> !cop_irq);

    p_doorbell_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cop_irq) |-> $past(host_wr && host_sel == 2'd3 && host_wdata[3]));

    p_hirq_int0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cop_set_int0 |-> ##2 host_irq);

    p_hirq_int1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cop_set_int1 |-> ##2 host_irq);

    p_host_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> !cop_gnt);

endmodule

bind shram_host_port shram_host_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel     (host_sel),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_wdata   (host_wdata),
    .host_rvalid  (host_rvalid),
    .host_irq     (host_irq),
    .cop_irq      (cop_irq),
    .cop_gnt      (cop_gnt),
    .cop_set_int0 (cop_set_int0),
    .cop_set_int1 (cop_set_int1),
    .ram_addr     (ram_addr),
    .ptr          (ptr),
    .autoinc      (autoinc)
);

// File: tb/shram_host_port_bench.sv
`timescale 1ns/1ps
module shram_host_port_bench;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        host_sel = '0;
    logic              host_wr = 1'b0;
    logic              host_rd = 1'b0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;
    logic              host_rvalid;
    logic              host_irq;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;
    logic              cop_run, cop_bypass, cop_irq, cop_gnt;
    logic              cop_wr = 1'b0;
    logic [ADDR_W-1:0] cop_addr = '0;
    logic [7:0]        cop_wdata = '0;
    logic              cop_set_int0 = 1'b0;
    logic              cop_set_int1 = 1'b0;

    int n_cmp  = 0;
    int n_miss = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    // small RAM model, indexed by the low address byte
    logic [7:0] mem [256];
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    end
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
        ram_rdata <= mem[ram_addr[7:0]];
    end

    shram_host_port #(.ADDR_W(ADDR_W)) u_shram_host_port (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .host_irq(host_irq),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .cop_run(cop_run), .cop_bypass(cop_bypass), .cop_irq(cop_irq),
        .cop_wr(cop_wr), .cop_addr(cop_addr), .cop_wdata(cop_wdata), .cop_gnt(cop_gnt),
        .cop_set_int0(cop_set_int0), .cop_set_int1(cop_set_int1)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic hw(input logic [1:0] sel, input logic [7:0] val);
        host_sel = sel; host_wdata = val; host_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input string req, input logic [1:0] sel, input logic [7:0] exp);
        host_sel = sel; host_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        host_rd = 1'b0;
        chk({req, " rvalid"}, {7'd0, host_rvalid}, 8'h01);
        chk(req, host_rdata, exp);
    endtask

    typedef struct packed {
        logic       is_rd;
        logic [1:0] sel;
        logic [7:0] val;
    } vec_t;

    localparam int NV = 13;
    // burst write then burst read with auto-advance (R2, R3, R4)
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd3, 8'h02}, '{1'b0, 2'd0, 8'h10}, '{1'b0, 2'd1, 8'h01},
        '{1'b0, 2'd2, 8'hAA}, '{1'b0, 2'd2, 8'h55}, '{1'b0, 2'd2, 8'h3C},
        '{1'b1, 2'd0, 8'h13}, '{1'b1, 2'd1, 8'h01}, '{1'b0, 2'd0, 8'h10},
        '{1'b1, 2'd2, 8'hAA}, '{1'b1, 2'd2, 8'h55}, '{1'b1, 2'd2, 8'h3C},
        '{1'b1, 2'd0, 8'h13}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 host_irq", {7'd0, host_irq}, 8'h00);
        chk("R1 cop_irq", {7'd0, cop_irq}, 8'h00);
        chk("R1 cop_run", {7'd0, cop_run}, 8'h00);
        chk("R1 cop_bypass", {7'd0, cop_bypass}, 8'h00);
        hr("R1 status", 2'd3, 8'h00);
        hr("R1 ptr lo", 2'd0, 8'h00);
        hr("R1 ptr hi", 2'd1, 8'h00);

        // table walk: R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) hr($sformatf("R2/R3/R4 step %0d", i), VECS[i].sel, VECS[i].val);
            else               hw(VECS[i].sel, VECS[i].val);
        end

        // R4 without auto-advance the pointer holds
        hw(2'd3, 8'h01);
        hw(2'd0, 8'h50);
        hw(2'd2, 8'h66);
        hr("R4 hold after write", 2'd0, 8'h50);
        hr("R4 data at held ptr", 2'd2, 8'h66);
        hr("R4 hold after read", 2'd0, 8'h50);

        // R5 wrap
        hw(2'd3, 8'h02);
        hw(2'd0, 8'hFF);
        hw(2'd1, 8'hFF);
        hw(2'd2, 8'h77);
        hr("R5 wrap lo", 2'd0, 8'h00);
        hr("R5 wrap hi", 2'd1, 8'h00);

        // R6 control bits and outputs
        hw(2'd3, 8'h05);
        chk("R6 cop_run", {7'd0, cop_run}, 8'h01);
        chk("R6 cop_bypass", {7'd0, cop_bypass}, 8'h01);
        hr("R6 status", 2'd3, 8'h05);
        hw(2'd3, 8'h00);
        chk("R6 run off", {7'd0, cop_run}, 8'h00);

        // R7 doorbell pulse
        hw(2'd3, 8'h0B);
        chk("R7 doorbell high", {7'd0, cop_irq}, 8'h01);
        @(negedge clk);
        chk("R7 doorbell low", {7'd0, cop_irq}, 8'h00);
        hr("R7 doorbell cleared", 2'd3, 8'h03);

        // R8 flag set and shared interrupt timing
        cop_set_int0 = 1'b1;
        @(posedge clk); @(negedge clk);
        cop_set_int0 = 1'b0;
        chk("R8 host_irq lag", {7'd0, host_irq}, 8'h00);
        @(negedge clk);
        chk("R8 host_irq up", {7'd0, host_irq}, 8'h01);
        hr("R8 int0 flag", 2'd3, 8'h13);
        cop_set_int1 = 1'b1;
        @(posedge clk); @(negedge clk);
        cop_set_int1 = 1'b0;
        hr("R8 both flags", 2'd3, 8'h33);

        // R9 clear only the written flag
        hw(2'd3, 8'h13);
        hr("R9 int1 kept", 2'd3, 8'h23);
        chk("R9 host_irq held", {7'd0, host_irq}, 8'h01);
        hw(2'd3, 8'h23);
        hr("R9 all clear", 2'd3, 8'h03);
        chk("R9 host_irq down", {7'd0, host_irq}, 8'h00);

        // R10 set beats simultaneous clear
        cop_set_int0 = 1'b1;
        host_sel = 2'd3; host_wdata = 8'h13; host_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        cop_set_int0 = 1'b0; host_wr = 1'b0;
        hr("R10 set wins", 2'd3, 8'h13);
        hw(2'd3, 8'h13);
        hr("R10 cleared after", 2'd3, 8'h03);

        // R11 coprocessor write when idle (liveness byte)
        cop_wr = 1'b1; cop_addr = 16'h0031; cop_wdata = 8'hFF;
        #1;
        chk("R11 grant idle", {7'd0, cop_gnt}, 8'h01);
        @(posedge clk); @(negedge clk);
        cop_wr = 1'b0;
        hw(2'd0, 8'h31);
        hw(2'd1, 8'h00);
        hr("R11 liveness seen", 2'd2, 8'hFF);
        hw(2'd0, 8'h31);
        hw(2'd2, 8'h00);
        hw(2'd0, 8'h31);
        hr("R11 liveness cleared", 2'd2, 8'h00);

        // R11 conflict: host window access wins (ptr now 0x0032)
        cop_wr = 1'b1; cop_addr = 16'h0040; cop_wdata = 8'h11;
        host_sel = 2'd2; host_wdata = 8'h99; host_wr = 1'b1;
        #1;
        chk("R11 no grant", {7'd0, cop_gnt}, 8'h00);
        @(posedge clk); @(negedge clk);
        cop_wr = 1'b0; host_wr = 1'b0;
        hw(2'd0, 8'h40);
        hr("R11 cop write dropped", 2'd2, 8'h00);
        hw(2'd0, 8'h32);
        hr("R11 host write kept", 2'd2, 8'h99);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule